// File: doc/BRIEF.md
# Receive interrupt coalescer

This block sits between a network receive path and the host interrupt line. It turns a stream of per-frame completion strobes into fewer interrupts. Frames are gathered into a bundle. One interrupt is raised when either of two things happens: the bundle reaches a programmable frame limit, or a dead-man countdown expires while frames are still waiting. The countdown is started by the first frame of each bundle.

A programmable length mask lets short frames skip the bundle and interrupt at once. A short frame is one whose length ANDed with the mask is zero, such as a TCP acknowledgement. Skipping this way leaves the bundle in progress exactly as it was. Three 16-bit settings are loaded through a small write port: the countdown reload, the frame limit and the length mask. The interrupt request is a level that is held until the host acknowledges it.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset the interrupt request is low and the settings hold their defaults: countdown reload 0x600, frame limit 6, length mask 0xFF80.
- R2: Settings are written while `cfg_wr` is high, selected by `cfg_sel`: 0 selects the countdown reload, 1 the frame limit and 2 the length mask; 3 selects nothing. A bundled frame that brings the bundle count up to the limit raises the interrupt on the clock edge that accepts the frame.
- R3: A frame limit of 1 raises an interrupt for every bundled frame. A limit of 0 behaves like 1.
- R4: A frame whose length ANDed with the mask is zero raises the interrupt on the edge that accepts it. With the mask 0xFF80, a frame of 127 bytes bypasses and a frame of 128 bytes is bundled.
- R5: A mask of 0xFFFF bypasses no frame of non-zero length. A mask of 0xF800 bypasses every frame of 2047 bytes or less and bundles a frame of 2048 bytes.
- R6: The first bundled frame of an empty bundle loads the countdown with the reload value R. Later frames do not restart it. If the limit is not reached first, the interrupt rises on the R-th clock edge after the edge that opened the bundle.
- R7: A bypassing frame changes neither the bundle count nor the countdown of the bundle in progress.
- R8: A frame limit of 0xFFFF disables the count limit, so only the countdown closes the bundle.
- R9: Raising a bundle interrupt empties the bundle and stops the countdown. When the limit and the countdown expiry fall on the same edge, a single interrupt results, and none follows after it is acknowledged.
- R10: The interrupt request stays high until `irq_ack` is sampled high, and it is low after that edge unless a new interrupt arises on the same edge.
- R11: A reload or limit written while a bundle is open applies from the next bundle. A mask write applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe: a frame has been received |
| frame_len | input | 16 | Length in bytes of the frame marked by `frame_done` |
| cfg_wr | input | 1 | Setting write enable |
| cfg_sel | input | 2 | Setting select (0 reload, 1 limit, 2 mask) |
| cfg_data | input | 16 | Setting write value |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| irq_req | output | 1 | Interrupt request level |

## Verification
Several properties are checked on every cycle. The request holds until it is acknowledged, and it never rises without a frame or an open bundle behind it. The open countdown steps down by exactly one. A bypassing frame leaves the count alone. The count never sits at or above the captured limit, and countdown expiry always empties the bundle. Other behaviour can only be shown by the bench's scenarios. These are the exact edge on which the countdown ends a bundle, the defaults after reset, the mask boundaries at 127/128 and 2047/2048 bytes, the single interrupt when limit and expiry coincide, and settings written mid-bundle taking effect only on the next bundle.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int PARAM_W = 16;
    localparam int SEL_W   = 2;

    typedef logic [PARAM_W-1:0] word_t;

    localparam word_t RELOAD_DFLT = 16'h0600;
    localparam word_t LIMIT_DFLT  = 16'd6;
    localparam word_t MASK_DFLT   = 16'hFF80;
    localparam word_t NO_LIMIT    = '1;

    typedef enum logic [SEL_W-1:0] {
        SEL_RELOAD = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_SPARE  = 2'd3
    } sel_e;

    typedef struct packed {
        word_t reload;
        word_t limit;
        word_t mask;
    } params_t;

    typedef struct packed {
        word_t cnt;    // frames in the open bundle, zero when empty
        word_t timer;  // dead-man countdown
        word_t lim;    // limit captured when the bundle opened
    } bundle_t;

endpackage

// File: rtl/rxc_param_regs.sv
module rxc_param_regs
    import rxc_pkg::*;
#(
    parameter word_t RELOAD_INIT = RELOAD_DFLT,
    parameter word_t LIMIT_INIT  = LIMIT_DFLT,
    parameter word_t MASK_INIT   = MASK_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  word_t            wr_data,
    output params_t          params_o
);

    params_t prm_d, prm_q;

    always_comb begin
        prm_d = prm_q;
        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_RELOAD: prm_d.reload = wr_data;
                SEL_LIMIT:  prm_d.limit  = wr_data;
                SEL_MASK:   prm_d.mask   = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prm_q <= '{reload: RELOAD_INIT, limit: LIMIT_INIT, mask: MASK_INIT};
        end else begin
            prm_q <= prm_d;
        end
    end

    assign params_o = prm_q;

endmodule

// File: rtl/rxc_short_filter.sv
module rxc_short_filter
    import rxc_pkg::*;
(
    input  logic  frame_done,
    input  word_t frame_len,
    input  word_t mask,
    output logic  bypass_o,
    output logic  join_o
);

    logic masked_zero;

    always_comb begin
        masked_zero = ((frame_len & mask) == '0);
        bypass_o    = frame_done && masked_zero;
        join_o      = frame_done && !masked_zero;
    end

endmodule

// File: rtl/rxc_bundle_ctrl.sv
module rxc_bundle_ctrl
    import rxc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  join_i,
    input  word_t reload_i,
    input  word_t limit_i,
    output logic  fire_o,
    output word_t cnt_o,
    output word_t timer_o,
    output word_t lim_o
);

    bundle_t st_d, st_q;

    logic  open_w;
    logic  timer_hit;
    logic  count_hit;
    word_t next_cnt;
    word_t eff_lim;

    always_comb begin
        st_d      = st_q;
        open_w    = (st_q.cnt != '0);
        eff_lim   = open_w ? st_q.lim : limit_i;

        if (!open_w) begin
            next_cnt = word_t'(1);
        end else if (st_q.cnt == '1) begin
            next_cnt = st_q.cnt;
        end else begin
            next_cnt = st_q.cnt + word_t'(1);
        end

        timer_hit = open_w && (st_q.timer <= word_t'(1));
        count_hit = join_i && (eff_lim != NO_LIMIT) && (next_cnt >= eff_lim);
        fire_o    = timer_hit || count_hit;

        if (fire_o) begin
            st_d.cnt   = '0;
            st_d.timer = '0;
        end else if (join_i && !open_w) begin
            st_d.cnt   = next_cnt;
            st_d.timer = reload_i;
            st_d.lim   = limit_i;
        end else if (open_w) begin
            st_d.timer = st_q.timer - word_t'(1);
            if (join_i) begin
                st_d.cnt = next_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, timer: '0, lim: LIMIT_DFLT};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign timer_o = st_q.timer;
    assign lim_o   = st_q.lim;

endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
    import rxc_pkg::*;
#(
    parameter word_t RELOAD_INIT = RELOAD_DFLT,
    parameter word_t LIMIT_INIT  = LIMIT_DFLT,
    parameter word_t MASK_INIT   = MASK_DFLT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [PARAM_W-1:0]  frame_len,
    input  logic                cfg_wr,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [PARAM_W-1:0]  cfg_data,
    input  logic                irq_ack,
    output logic                irq_req
);

    params_t prm_w;
    logic    bypass_w;
    logic    join_w;
    logic    fire_w;
    word_t   cnt_w;
    word_t   timer_w;
    word_t   lim_w;
    logic    irq_d, irq_q;

    rxc_param_regs #(
        .RELOAD_INIT (RELOAD_INIT),
        .LIMIT_INIT  (LIMIT_INIT),
        .MASK_INIT   (MASK_INIT)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_data),
        .params_o (prm_w)
    );

    rxc_short_filter filt_i (
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .mask       (prm_w.mask),
        .bypass_o   (bypass_w),
        .join_o     (join_w)
    );

    rxc_bundle_ctrl bund_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .join_i   (join_w),
        .reload_i (prm_w.reload),
        .limit_i  (prm_w.limit),
        .fire_o   (fire_w),
        .cnt_o    (cnt_w),
        .timer_o  (timer_w),
        .lim_o    (lim_w)
    );

    always_comb begin
        irq_d = fire_w || bypass_w || (irq_q && !irq_ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_req = irq_q;

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker
    import rxc_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  irq_req,
    input logic  irq_ack,
    input logic  frame_done,
    input logic  bypass,
    input logic  joined,
    input word_t cnt,
    input word_t timer,
    input word_t lim
);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(frame_done) || ($past(cnt) != '0)));

    // R6
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && timer > word_t'(1) && !joined) |=> (timer == $past(timer) - word_t'(1)));

    // R7
    bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && cnt != '0 && timer > word_t'(1)) |=> (cnt == $past(cnt)));

    // R2
    below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) || (cnt < lim) || (lim == NO_LIMIT));

    // R9
    expiry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && timer <= word_t'(1)) |=> (cnt == '0 && irq_req));

endmodule

bind rx_irq_coalescer rxc_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_ack    (irq_ack),
    .frame_done (frame_done),
    .bypass     (bypass_w),
    .joined     (join_w),
    .cnt        (cnt_w),
    .timer      (timer_w),
    .lim        (lim_w)
);

// File: tb/rx_irq_coalescer_tb_top.sv
`timescale 1ns/1ps
module rx_irq_coalescer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rx_irq_coalescer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req)
    );

    typedef struct packed {
        logic [15:0] lim;
        logic [15:0] mask;
        logic [15:0] len;
        logic [7:0]  n;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{16'd3, 16'hFF80, 16'd200,  8'd3, 1'b1, 4'd2},  // R2 limit reached
        '{16'd3, 16'hFF80, 16'd200,  8'd2, 1'b0, 4'd2},  // R2 below limit
        '{16'd1, 16'hFF80, 16'd300,  8'd1, 1'b1, 4'd3},  // R3 limit 1
        '{16'd0, 16'hFF80, 16'd300,  8'd1, 1'b1, 4'd3},  // R3 limit 0
        '{16'd6, 16'hFF80, 16'd127,  8'd1, 1'b1, 4'd4},  // R4 127 bypasses
        '{16'd6, 16'hFF80, 16'd128,  8'd1, 1'b0, 4'd4},  // R4 128 bundled
        '{16'd6, 16'hFFFF, 16'd1,    8'd1, 1'b0, 4'd5},  // R5 mask off
        '{16'd6, 16'hF800, 16'd2047, 8'd1, 1'b1, 4'd5},  // R5 2047 bypasses
        '{16'd6, 16'hF800, 16'd2048, 8'd1, 1'b0, 4'd5}   // R5 2048 bundled
    };

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: irq_req=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic send(input logic [15:0] len);
        @(negedge clk);
        frame_done = 1'b1;
        frame_len  = len;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_sel  = sel;
        cfg_data = val;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: irq_req=%0d expected=finished", irq_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(irq_req, 1'b0, "R1 reset");
        rst_n = 1'b1;
        idle(1);
        check(irq_req, 1'b0, "R1 after reset");

        // R1 default limit 6
        for (int i = 0; i < 5; i++) send(16'd1500);
        check(irq_req, 1'b0, "R1 five frames");
        send(16'd1500);
        check(irq_req, 1'b1, "R1 sixth frame");
        ack();
        check(irq_req, 1'b0, "R10 ack clears");

        // R1/R6 default reload 0x600
        send(16'd1500);
        idle(16'h600 - 1);
        check(irq_req, 1'b0, "R6 before expiry");
        idle(1);
        check(irq_req, 1'b1, "R6 at expiry");
        // R10 held until ack
        idle(20);
        check(irq_req, 1'b1, "R10 held");
        ack();
        check(irq_req, 1'b0, "R10 released");

        // Vector walk
        wr(2'd0, 16'd40);
        for (int v = 0; v < 9; v++) begin
            wr(2'd1, VECS[v].lim);
            wr(2'd2, VECS[v].mask);
            for (int f = 0; f < int'(VECS[v].n); f++) send(VECS[v].len);
            check(irq_req, VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
            idle(60);
            ack();
            check(irq_req, 1'b0, "R10 vector cleanup");
        end
        wr(2'd2, 16'hFF80);

        // R7 bypass leaves count
        wr(2'd1, 16'd3);
        send(16'd500);
        send(16'd500);
        send(16'd10);
        check(irq_req, 1'b1, "R7 short frame irq");
        ack();
        check(irq_req, 1'b0, "R7 ack");
        send(16'd500);
        check(irq_req, 1'b1, "R7 count kept");
        ack();

        // R7 bypass leaves timer
        wr(2'd1, 16'd6);
        send(16'd500);
        send(16'd20);
        check(irq_req, 1'b1, "R7 bypass during bundle");
        ack();
        idle(35);
        check(irq_req, 1'b0, "R7 timer not yet expired");
        idle(1);
        check(irq_req, 1'b1, "R7 timer kept");
        ack();

        // R8 no limit
        wr(2'd1, 16'hFFFF);
        for (int i = 0; i < 10; i++) send(16'd600);
        check(irq_req, 1'b0, "R8 no count limit");
        idle(21);
        check(irq_req, 1'b0, "R8 before expiry");
        idle(1);
        check(irq_req, 1'b1, "R8 timer closes");
        ack();

        // R9 limit and expiry coincide
        wr(2'd0, 16'd4);
        wr(2'd1, 16'd2);
        send(16'd600);
        idle(2);
        send(16'd600);
        check(irq_req, 1'b1, "R9 coincident irq");
        ack();
        idle(10);
        check(irq_req, 1'b0, "R9 single irq");
        send(16'd600);
        check(irq_req, 1'b0, "R9 bundle emptied");
        idle(6);
        ack();

        // R11 mid-bundle write
        wr(2'd0, 16'd40);
        wr(2'd1, 16'd6);
        send(16'd700);
        wr(2'd1, 16'd2);
        send(16'd700);
        check(irq_req, 1'b0, "R11 old limit kept");
        idle(35);
        check(irq_req, 1'b0, "R11 before expiry");
        idle(1);
        check(irq_req, 1'b1, "R11 expiry");
        ack();
        send(16'd700);
        send(16'd700);
        check(irq_req, 1'b1, "R11 new limit");
        ack();

        // R2 spare select writes nothing
        wr(2'd3, 16'd1);
        send(16'd700);
        check(irq_req, 1'b0, "R2 spare select ignored");
        send(16'd700);
        check(irq_req, 1'b1, "R2 limit still 2");
        ack();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule